// File: doc/BRIEF.md
# LIN Break/Synch Baud Detector

This block watches the receive line of a LIN-style serial link and picks out the header that opens every frame: a long dominant (low) break, a short recessive delimiter, and then the synch byte 0x55. It checks the break against a minimum and a maximum length, expressed in bit times of a nominal bit period supplied on `bit_len` (clock cycles per bit). It then times the synch byte with a counter and reports a per-bit divisor that a baud-rate generator can take over.

The line passes through a two-flop synchronizer before any decision is made. A bit-phase timer measures the break and the delimiter in whole bit times. A saturating span counter measures the synch byte from its first falling edge to its last. The 0x55 byte is sent LSB first with one stop bit, so its falling edges come at the start bit and at data bits 1, 3, 5 and 7. The first and fifth of those edges are 8 bit times apart, so the divisor is the span shifted right by three. While a header is in progress, `tx_hold` tells the local transmitter to keep off the line.

The controller has four states:
- `ST_HUNT`: waiting for a falling edge.
- `ST_BREAK`: timing the low period.
- `ST_DELIM`: timing the delimiter.
- `ST_MEAS`: counting synch edges.

The transitions are:
- HUNT to BREAK on a falling edge.
- BREAK to DELIM when the line rises after a long enough low period. This is a valid break.
- BREAK to HUNT when the line rises too early (break too short).
- BREAK to HUNT when the low period overruns (break timeout).
- DELIM to MEAS on a falling edge.
- DELIM to HUNT when the delimiter is too long.
- MEAS to HUNT on the fifth falling edge. This is the end of measurement.
- MEAS to HUNT when the counter saturates (synch timeout).
- Any state to HUNT while `det_en` is low.

Top module: `lin_brk_sync_det`

## Requirements
- R1: While `rst_n` is low, and after its release, `brk_pulse`, `brk_tmo`, `div_load`, `syn_tmo` and `tx_hold` are low and `div_val` is 0.
- R2: Let N be `bit_len` and L the low time in clocks. A low period with 11·N ≤ L ≤ 22·N, followed by a return high, raises `brk_pulse` for exactly one cycle.
- R3: A low period longer than 22·N raises `brk_tmo` for one cycle, 22·N+3 clocks after the falling edge is driven at `rxd`. It gives no `brk_pulse`.
- R4: A low period shorter than 11·N gives no pulse and no error; the detector goes back to hunting.
- R5: After a valid break and delimiter, the synch field has five falling edges: the start bit and data bits 1, 3, 5 and 7 of 0x55, sent LSB first. Let S be the clock span from the first to the fifth of these edges. `div_val` then becomes S>>3, and `div_load` is high for exactly one cycle.
- R6: A span of up to 32767 clocks (0x7FFF, the 15-bit counter limit) loads normally. A longer span raises `syn_tmo` for one cycle, with no load, and `div_val` keeps its value.
- R7: With `meas_en` low, the break is still reported and the synch byte is consumed. There is no `div_load` and no `syn_tmo`, and `div_val` keeps its old value.
- R8: `tx_hold` goes high once the low period reaches 11·N. It stays high through the delimiter and the synch byte, up to and including the cycle of the fifth falling edge, and is low otherwise.
- R9: With `det_en` low, the block gives no pulse, no error and no load, and `tx_hold` stays low.
- R10: A delimiter of up to 4·N clocks is accepted. A longer one drops the header silently: no load and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Receive line, idle high |
| det_en | input | 1 | Enables break and synch detection |
| meas_en | input | 1 | Enables loading of the measured divisor |
| bit_len | input | BIT_W (12) | Nominal bit period in clocks, at least 2 |
| brk_pulse | output | 1 | One-cycle strobe: valid break seen |
| brk_tmo | output | 1 | One-cycle strobe: break too long |
| div_load | output | 1 | One-cycle strobe: `div_val` updated |
| div_val | output | CNT_W-3 (12) | Measured clocks per bit |
| syn_tmo | output | 1 | One-cycle strobe: synch span over the counter limit |
| tx_hold | output | 1 | Transmitter hold while a header is received |

## Verification
A controller stuck in the wrong state shows at once on `tx_hold`. The bench counts the `tx_hold` cycles exactly, so a stuck state is visible within the same header. A bit-phase or span counter that is off by one moves the break acceptance edges at 11·N and 22·N, the exact clock of `brk_tmo`, or the S>>3 quotient. The sweeps step one clock across each of these edges, so an off-by-one error changes a pulse count or the loaded value within a single frame. An edge-count fault ends the measurement early or late, and the divisor sweep over every span from 15 to 90 clocks shows it as a wrong quotient.

// File: rtl/lin_det_pkg.sv
package lin_det_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_BREAK = 2'd1,
        ST_DELIM = 2'd2,
        ST_MEAS  = 2'd3
    } det_state_t;

    // 0x55 LSB first: falls at start, d1, d3, d5, d7 -> 5 edges over 8 bits
    localparam int SYNC_EDGES = 5;
    localparam int SPAN_SHIFT = 3;

endpackage

// File: rtl/lin_rx_edge.sv
module lin_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev;
    logic              lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], rxd};
            prev <= sh[STAGES-1];
        end
    end

    assign lvl  = sh[STAGES-1];
    assign fall = prev & ~lvl;
    assign rise = ~prev & lvl;
endmodule

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
    parameter int BIT_W = 12,
    parameter int NB_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [BIT_W-1:0] bit_len,
    output logic [NB_W-1:0]  nbits
);
    // invariant: nbits*bit_len + phase == clocks since restart
    logic [BIT_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            nbits <= '0;
        end else if (restart) begin
            phase <= BIT_W'(1);
            nbits <= '0;
        end else if (phase >= bit_len - BIT_W'(1)) begin
            phase <= '0;
            if (nbits != '1) begin
                nbits <= nbits + NB_W'(1);
            end
        end else begin
            phase <= phase + BIT_W'(1);
        end
    end
endmodule

// File: rtl/lin_span_ctr.sv
module lin_span_ctr #(
    parameter int CNT_W = 15,
    parameter int SHIFT = 3,
    localparam int Q_W  = CNT_W - SHIFT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    output logic           sat,
    output logic [Q_W-1:0] quot
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CNT_W'(1);
        end else if (!sat) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign sat  = &cnt;
    assign quot = cnt[CNT_W-1:SHIFT];
endmodule

// File: rtl/lin_brk_sync_det.sv
module lin_brk_sync_det
    import lin_det_pkg::*;
#(
    parameter int BIT_W   = 12,
    parameter int CNT_W   = 15,
    parameter int BRK_MIN = 11,
    parameter int BRK_MAX = 22,
    parameter int DLM_MAX = 4,
    parameter int SYNC_FF = 2,
    localparam int DIV_W  = CNT_W - SPAN_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             det_en,
    input  logic             meas_en,
    input  logic [BIT_W-1:0] bit_len,
    output logic             brk_pulse,
    output logic             brk_tmo,
    output logic             div_load,
    output logic [DIV_W-1:0] div_val,
    output logic             syn_tmo,
    output logic             tx_hold
);
    localparam int NB_W = $clog2(BRK_MAX + 1);
    localparam int FC_W = $clog2(SYNC_EDGES);

    det_state_t       state, nxt;
    logic             fall, rise;
    logic [NB_W-1:0]  nbits;
    logic             tmr_restart, span_restart;
    logic             span_sat;
    logic [DIV_W-1:0] span_quot;
    logic [FC_W-1:0]  fcnt;
    logic             ev_brk, ev_btmo, ev_done, ev_stmo;

    lin_rx_edge #(.STAGES(SYNC_FF)) u_edge (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .fall(fall), .rise(rise)
    );

    lin_bit_timer #(.BIT_W(BIT_W), .NB_W(NB_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
        .bit_len(bit_len), .nbits(nbits)
    );

    lin_span_ctr #(.CNT_W(CNT_W), .SHIFT(SPAN_SHIFT)) u_span (
        .clk(clk), .rst_n(rst_n), .restart(span_restart),
        .sat(span_sat), .quot(span_quot)
    );

    // next state and transition events
    always_comb begin
        nxt          = state;
        tmr_restart  = 1'b0;
        span_restart = 1'b0;
        ev_brk       = 1'b0;
        ev_btmo      = 1'b0;
        ev_done      = 1'b0;
        ev_stmo      = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (fall) begin
                    nxt         = ST_BREAK;
                    tmr_restart = 1'b1;
                end
            end
            ST_BREAK: begin
                if (rise) begin
                    tmr_restart = 1'b1;
                    if (nbits >= NB_W'(BRK_MIN)) begin
                        nxt    = ST_DELIM;
                        ev_brk = 1'b1;
                    end else begin
                        nxt = ST_HUNT;
                    end
                end else if (nbits >= NB_W'(BRK_MAX)) begin
                    nxt     = ST_HUNT;
                    ev_btmo = 1'b1;
                end
            end
            ST_DELIM: begin
                if (fall) begin
                    nxt          = ST_MEAS;
                    span_restart = 1'b1;
                end else if (nbits >= NB_W'(DLM_MAX)) begin
                    nxt = ST_HUNT;
                end
            end
            ST_MEAS: begin
                if (fall && fcnt == FC_W'(SYNC_EDGES - 2)) begin
                    nxt     = ST_HUNT;
                    ev_done = 1'b1;
                end else if (span_sat) begin
                    nxt     = ST_HUNT;
                    ev_stmo = 1'b1;
                end
            end
        endcase
        if (!det_en) begin
            nxt     = ST_HUNT;
            ev_brk  = 1'b0;
            ev_btmo = 1'b0;
            ev_done = 1'b0;
            ev_stmo = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= nxt;
        end
    end

    // synch edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt <= '0;
        end else if (state == ST_DELIM && fall) begin
            fcnt <= '0;
        end else if (state == ST_MEAS && fall) begin
            fcnt <= fcnt + FC_W'(1);
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_pulse <= 1'b0;
            brk_tmo   <= 1'b0;
            div_load  <= 1'b0;
            syn_tmo   <= 1'b0;
            div_val   <= '0;
        end else begin
            brk_pulse <= ev_brk;
            brk_tmo   <= ev_btmo;
            div_load  <= ev_done & meas_en;
            syn_tmo   <= ev_stmo & meas_en;
            if (ev_done && meas_en) begin
                div_val <= span_quot;
            end
        end
    end

    assign tx_hold = (state == ST_DELIM) || (state == ST_MEAS) ||
                     (state == ST_BREAK && nbits >= NB_W'(BRK_MIN));
endmodule

// File: rtl/lin_brk_sync_chk.sv
module lin_brk_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic det_en,
    input logic meas_en,
    input logic brk_pulse,
    input logic brk_tmo,
    input logic div_load,
    input logic syn_tmo,
    input logic tx_hold
);
    a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !div_load);

    a_r7_load_needs_meas: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |-> $past(meas_en));

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(det_en) |-> !(brk_pulse || brk_tmo || div_load || syn_tmo));

    a_r8_hold_after_break: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> tx_hold);

    a_r3_tmo_releases: assert property (@(posedge clk) disable iff (!rst_n)
        brk_tmo |-> !tx_hold);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({brk_pulse, brk_tmo, div_load, syn_tmo}));
endmodule

bind lin_brk_sync_det lin_brk_sync_chk u_chk (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .meas_en(meas_en),
    .brk_pulse(brk_pulse), .brk_tmo(brk_tmo), .div_load(div_load),
    .syn_tmo(syn_tmo), .tx_hold(tx_hold)
);

// File: tb/tb_lin_brk_sync_det.sv
module tb_lin_brk_sync_det;
    localparam int BIT_W = 12;
    localparam int DIV_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rxd = 1'b1;
    logic             det_en = 1'b1;
    logic             meas_en = 1'b1;
    logic [BIT_W-1:0] bit_len = 12'd8;
    logic             brk_pulse, brk_tmo, div_load, syn_tmo, tx_hold;
    logic [DIV_W-1:0] div_val;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int n_brk, n_bto, n_ld, n_sto, n_hold, bto_cyc, last_div;
    bit done = 0;
    bit mon_on = 0;

    lin_brk_sync_det dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .det_en(det_en),
        .meas_en(meas_en), .bit_len(bit_len), .brk_pulse(brk_pulse),
        .brk_tmo(brk_tmo), .div_load(div_load), .div_val(div_val),
        .syn_tmo(syn_tmo), .tx_hold(tx_hold)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mon_on) begin
            if (brk_pulse) n_brk++;
            if (brk_tmo) begin n_bto++; bto_cyc = cyc; end
            if (div_load) begin n_ld++; last_div = int'(div_val); end
            if (syn_tmo) n_sto++;
            if (tx_hold) n_hold++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        n_brk = 0; n_bto = 0; n_ld = 0; n_sto = 0; n_hold = 0; bto_cyc = 0;
    endtask

    task automatic seg(input logic lv, input int n);
        rxd = lv;
        repeat (n) @(negedge clk);
    endtask

    // 0x55 LSB first: start, d0..d5 of m clocks, d6 of last_hi, d7, stop
    task automatic send_sync(input int m, input int last_hi);
        seg(0, m); seg(1, m); seg(0, m); seg(1, m);
        seg(0, m); seg(1, m); seg(0, m); seg(1, last_hi);
        seg(0, m); seg(1, m);
    endtask

    task automatic settle();
        seg(1, 60);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 brk_pulse", int'(brk_pulse), 0);
        chk("R1 div_load", int'(div_load), 0);
        chk("R1 tx_hold", int'(tx_hold), 0);
        chk("R1 div_val", int'(div_val), 0);
        rst_n = 1'b1;
        settle();
        chk("R1 after release", int'({brk_tmo, syn_tmo, tx_hold}), 0);
        mon_on = 1;

        // R2/R3/R4: break length sweep across both limits
        for (int n = 4; n <= 7; n++) begin
            for (int k = 0; k < 4; k++) begin
                int len, c0;
                bit ok;
                len = (k == 0) ? 11*n-1 : (k == 1) ? 11*n : (k == 2) ? 22*n : 22*n+1;
                ok  = (k == 1) || (k == 2);
                bit_len = BIT_W'(n);
                clr();
                c0 = cyc;
                seg(0, len);
                seg(1, n);
                send_sync(n, n);
                settle();
                chk(ok ? "R2 break accepted" : "R4 R3 break rejected", n_brk, ok ? 1 : 0);
                chk("R3 timeout count", n_bto, (k == 3) ? 1 : 0);
                if (k == 3) chk("R3 timeout cycle", bto_cyc - c0, 22*n + 3);
                chk("R5 load count", n_ld, ok ? 1 : 0);
                if (ok) chk("R5 divisor nominal", last_div, n);
            end
        end

        // R5: divisor over every span 15..90
        bit_len = 12'd4;
        for (int s = 15; s <= 90; s++) begin
            clr();
            seg(0, 48); seg(1, 4);
            send_sync(2, s - 14);
            settle();
            chk("R5 load count", n_ld, 1);
            chk("R5 divisor", last_div, s >> 3);
        end

        // R6: counter limit
        clr();
        seg(0, 48); seg(1, 4); send_sync(2, 32767 - 14); settle();
        chk("R6 span at limit loads", n_ld, 1);
        chk("R6 divisor at limit", last_div, 4095);
        chk("R6 no timeout at limit", n_sto, 0);
        clr();
        seg(0, 48); seg(1, 4); send_sync(2, 32768 - 14); settle();
        chk("R6 over limit no load", n_ld, 0);
        chk("R6 over limit timeout", n_sto, 1);
        chk("R6 divisor kept", int'(div_val), 4095);

        // R7: measurement disabled
        meas_en = 1'b0;
        clr();
        seg(0, 48); seg(1, 4); send_sync(3, 3); settle();
        chk("R7 break still seen", n_brk, 1);
        chk("R7 no load", n_ld, 0);
        chk("R7 divisor kept", int'(div_val), 4095);
        clr();
        seg(0, 48); seg(1, 4); send_sync(2, 32768 - 14); settle();
        chk("R7 no timeout", n_sto, 0);
        meas_en = 1'b1;

        // R8: hold window, N=5, L=70, D=5, span 40 -> 70+5+40-55+1 cycles
        bit_len = 12'd5;
        clr();
        seg(0, 40);
        chk("R8 hold low early in break", int'(tx_hold), 0);
        seg(0, 30);
        chk("R8 hold high in long break", int'(tx_hold), 1);
        seg(1, 5);
        chk("R8 hold high in delimiter", int'(tx_hold), 1);
        send_sync(5, 5);
        settle();
        chk("R8 hold released", int'(tx_hold), 0);
        chk("R8 hold cycles", n_hold, 61);
        chk("R8 divisor", last_div, 5);

        // R9: detection disabled
        det_en = 1'b0;
        clr();
        seg(0, 60); seg(1, 5); send_sync(5, 5); settle();
        chk("R9 no break", n_brk, 0);
        chk("R9 no load", n_ld, 0);
        chk("R9 no hold", n_hold, 0);
        det_en = 1'b1;

        // R10: delimiter limit
        clr();
        seg(0, 60); seg(1, 20); send_sync(6, 6); settle();
        chk("R10 delimiter 4N loads", n_ld, 1);
        chk("R10 delimiter 4N divisor", last_div, 6);
        clr();
        seg(0, 60); seg(1, 21); send_sync(6, 6); settle();
        chk("R10 delimiter over 4N no load", n_ld, 0);
        chk("R10 break still seen", n_brk, 1);
        chk("R10 no error", n_bto + n_sto, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule